// File: doc/BRIEF.md
# Static Taken-Hint Redirect for the Decode Stage

This block sits beside the decoders of a multi-lane decode stage. Each cycle it looks at up to `LANES` decoded instructions, oldest in lane 0. It picks out a conditional branch whose prefix byte, placed directly before the opcode, is the taken hint. If the dynamic predictor had no entry for that branch, because it has never seen the branch or has evicted it, the block steers fetch to the branch's computed target.

The redirect comes out one clock after the decode cycle. It carries the target, the address of the hinted branch and the lane it came from. It also carries a kill mask that names every lane younger than the hinted branch in that decode group. The fetch unit uses the mask to drop those bytes.

The not-taken hint prefix is recognised but never acts. A branch the predictor already covered keeps its dynamic prediction. A back-end flush in the decode cycle cancels the redirect.

Top module: `shb_hint_redirect`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `rd_valid` is 0 and `kill_mask` is all zeros.
- R2: A lane is a candidate when all of these hold: `dec_valid` is 1, `dec_pfx_present` is 1, the lane's prefix byte (bits [8i+7:8i] of `dec_pfx_byte`) equals 8'h3E, `dec_is_jcc` is 1 and `bp_hit` is 0. A candidate with `be_flush` low gives `rd_valid`=1 one cycle later, with `rd_target` and `rd_pc` equal to that lane's target and address slices (bits [AW*i +: AW]).
- R3: A prefix byte of 8'h2E (not-taken hint) never produces a redirect.
- R4: A lane whose `bp_hit` is 1 never produces a redirect, whatever its prefix.
- R5: The taken-hint byte has no effect on a lane with `dec_is_jcc`=0. It also has no effect when `dec_pfx_present`=0, even if the byte field holds 8'h3E.
- R6: When several lanes are candidates, the lowest-numbered lane (the oldest) wins, and `rd_lane` gives its index.
- R7: With `rd_valid`=1, `kill_mask` bit k is 1 exactly for the lanes k greater than `rd_lane`. With `rd_valid`=0 the mask is zero.
- R8: When `be_flush` is 1 in the decode cycle, no redirect results from that cycle.
- R9: The redirect is a single-cycle pulse. A decode cycle with no candidate gives `rd_valid`=0 one cycle later.
- R10: A lane with `dec_valid`=0 never produces a redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | LANES | Lane holds a decoded instruction |
| dec_pfx_present | input | LANES | A prefix byte sits directly before the opcode |
| dec_pfx_byte | input | LANES*8 | That prefix byte, one byte per lane |
| dec_is_jcc | input | LANES | Opcode is a conditional branch |
| dec_target | input | LANES*AW | Computed branch target per lane |
| dec_pc | input | LANES*AW | Instruction address per lane |
| bp_hit | input | LANES | Dynamic predictor supplied a prediction for this lane |
| be_flush | input | 1 | Back-end flush active this cycle |
| rd_valid | output | 1 | Redirect request |
| rd_target | output | AW | Redirect target |
| rd_pc | output | AW | Address of the hinted branch |
| rd_lane | output | LW | Lane of the hinted branch |
| kill_mask | output | LANES | Younger lanes to discard |

## Verification
The bench builds the block with five lanes and a 32-bit address. The odd lane count exercises a priority chain whose length is not a power of two, and it leaves `rd_lane` with encodings that no lane uses. Five lanes also leave room for a candidate in the middle lane with both older and younger lanes beside it, so every kill-mask shape from four bits down to none can occur. The random mix draws hint bytes, prefix-present flags, predictor hits and back-end flushes independently, so that candidates that compete in one cycle are common.

// File: rtl/shb_pkg.sv
package shb_pkg;
  localparam logic [7:0] TAKEN_HINT_BYTE     = 8'h3E;
  localparam logic [7:0] NOT_TAKEN_HINT_BYTE = 8'h2E;

  typedef enum logic [1:0] {
    HINT_NONE,
    HINT_TAKEN,
    HINT_NOT_TAKEN,
    HINT_OTHER
  } hint_kind_t;

  function automatic hint_kind_t classify_hint(input logic present, input logic [7:0] pfx);
    if (!present)                         return HINT_NONE;
    else if (pfx == TAKEN_HINT_BYTE)      return HINT_TAKEN;
    else if (pfx == NOT_TAKEN_HINT_BYTE)  return HINT_NOT_TAKEN;
    else                                  return HINT_OTHER;
  endfunction
endpackage

// File: rtl/shb_lane_qual.sv
module shb_lane_qual
  import shb_pkg::*;
(
  input  logic       valid,
  input  logic       pfx_present,
  input  logic [7:0] pfx_byte,
  input  logic       is_jcc,
  input  logic       bp_hit,
  output logic       cand,
  output logic       nt_hint
);
  hint_kind_t kind;

  always_comb begin
    kind    = classify_hint(pfx_present, pfx_byte);
    cand    = valid & is_jcc & ~bp_hit & (kind == HINT_TAKEN);
    nt_hint = valid & (kind == HINT_NOT_TAKEN);
  end
endmodule

// File: rtl/shb_oldest_pick.sv
module shb_oldest_pick #(
  parameter int LANES = 4,
  parameter int LW    = 2
) (
  input  logic [LANES-1:0] cand,
  output logic [LANES-1:0] win_oh,
  output logic [LANES-1:0] younger,
  output logic [LW-1:0]    win_idx,
  output logic             any_cand
);
  logic [LANES:0] seen;

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < LANES; i++) begin : g_chain
    assign seen[i+1]  = seen[i] | cand[i];
    assign win_oh[i]  = cand[i] & ~seen[i];
    assign younger[i] = seen[i];
  end

  assign any_cand = seen[LANES];

  always_comb begin
    win_idx = '0;
    for (int i = 0; i < LANES; i++) begin
      if (win_oh[i]) win_idx = win_idx | LW'(i);
    end
  end
endmodule

// File: rtl/shb_target_mux.sv
module shb_target_mux #(
  parameter int LANES = 4,
  parameter int AW    = 48
) (
  input  logic [LANES-1:0]    win_oh,
  input  logic [LANES*AW-1:0] lane_target,
  input  logic [LANES*AW-1:0] lane_pc,
  output logic [AW-1:0]       sel_target,
  output logic [AW-1:0]       sel_pc
);
  always_comb begin
    sel_target = '0;
    sel_pc     = '0;
    for (int i = 0; i < LANES; i++) begin
      if (win_oh[i]) begin
        sel_target = sel_target | lane_target[i*AW +: AW];
        sel_pc     = sel_pc     | lane_pc[i*AW +: AW];
      end
    end
  end
endmodule

// File: rtl/shb_redirect_reg.sv
module shb_redirect_reg #(
  parameter int LANES = 4,
  parameter int AW    = 48,
  parameter int LW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [AW-1:0]    sel_target,
  input  logic [AW-1:0]    sel_pc,
  input  logic [LW-1:0]    sel_lane,
  input  logic [LANES-1:0] younger,
  output logic             rd_valid,
  output logic [AW-1:0]    rd_target,
  output logic [AW-1:0]    rd_pc,
  output logic [LW-1:0]    rd_lane,
  output logic [LANES-1:0] kill_mask
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid  <= 1'b0;
      rd_target <= '0;
      rd_pc     <= '0;
      rd_lane   <= '0;
      kill_mask <= '0;
    end else begin
      rd_valid  <= fire;
      rd_target <= fire ? sel_target : '0;
      rd_pc     <= fire ? sel_pc     : '0;
      rd_lane   <= fire ? sel_lane   : '0;
      kill_mask <= fire ? younger    : '0;
    end
  end
endmodule

// File: rtl/shb_hint_redirect.sv
module shb_hint_redirect #(
  parameter int LANES = 4,
  parameter int AW    = 48,
  localparam int LW   = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LANES-1:0]    dec_valid,
  input  logic [LANES-1:0]    dec_pfx_present,
  input  logic [LANES*8-1:0]  dec_pfx_byte,
  input  logic [LANES-1:0]    dec_is_jcc,
  input  logic [LANES*AW-1:0] dec_target,
  input  logic [LANES*AW-1:0] dec_pc,
  input  logic [LANES-1:0]    bp_hit,
  input  logic                be_flush,
  output logic                rd_valid,
  output logic [AW-1:0]       rd_target,
  output logic [AW-1:0]       rd_pc,
  output logic [LW-1:0]       rd_lane,
  output logic [LANES-1:0]    kill_mask
);
  // Named internal events, also observed by the bound checker
  logic [LANES-1:0] cand;
  logic [LANES-1:0] nt_hint;
  logic [LANES-1:0] win_oh;
  logic [LANES-1:0] younger;
  logic [LW-1:0]    win_idx;
  logic             any_cand;
  logic             fire;
  logic [AW-1:0]    sel_target;
  logic [AW-1:0]    sel_pc;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    shb_lane_qual u_qual (
      .valid       (dec_valid[i]),
      .pfx_present (dec_pfx_present[i]),
      .pfx_byte    (dec_pfx_byte[i*8 +: 8]),
      .is_jcc      (dec_is_jcc[i]),
      .bp_hit      (bp_hit[i]),
      .cand        (cand[i]),
      .nt_hint     (nt_hint[i])
    );
  end

  shb_oldest_pick #(.LANES(LANES), .LW(LW)) u_pick (
    .cand     (cand),
    .win_oh   (win_oh),
    .younger  (younger),
    .win_idx  (win_idx),
    .any_cand (any_cand)
  );

  shb_target_mux #(.LANES(LANES), .AW(AW)) u_mux (
    .win_oh      (win_oh),
    .lane_target (dec_target),
    .lane_pc     (dec_pc),
    .sel_target  (sel_target),
    .sel_pc      (sel_pc)
  );

  // A back-end flush outranks any decode-time redirect (R8)
  assign fire = any_cand & ~be_flush;

  shb_redirect_reg #(.LANES(LANES), .AW(AW), .LW(LW)) u_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .sel_target (sel_target),
    .sel_pc     (sel_pc),
    .sel_lane   (win_idx),
    .younger    (younger),
    .rd_valid   (rd_valid),
    .rd_target  (rd_target),
    .rd_pc      (rd_pc),
    .rd_lane    (rd_lane),
    .kill_mask  (kill_mask)
  );
endmodule

// File: rtl/shb_hint_redirect_chk.sv
module shb_hint_redirect_chk #(
  parameter int LANES = 4,
  parameter int LW    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             be_flush,
  input logic             any_cand,
  input logic [LANES-1:0] win_oh,
  input logic [LANES-1:0] nt_hint,
  input logic             rd_valid,
  input logic [LW-1:0]    rd_lane,
  input logic [LANES-1:0] kill_mask
);
  logic [LANES-1:0] exp_kill;

  always_comb begin
    exp_kill = '0;
    for (int i = 0; i < LANES; i++) exp_kill[i] = (i > int'(rd_lane));
  end

  assert_single_winner_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_oh));

  assert_nt_never_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (win_oh & nt_hint) == '0);

  assert_cand_redirects_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (any_cand && !be_flush) |=> rd_valid);

  assert_flush_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    be_flush |=> !rd_valid);

  assert_idle_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !any_cand |=> !rd_valid);

  assert_kill_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (kill_mask == exp_kill));

  assert_kill_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (kill_mask == '0));
endmodule

bind shb_hint_redirect shb_hint_redirect_chk #(.LANES(LANES), .LW(LW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .be_flush  (be_flush),
  .any_cand  (any_cand),
  .win_oh    (win_oh),
  .nt_hint   (nt_hint),
  .rd_valid  (rd_valid),
  .rd_lane   (rd_lane),
  .kill_mask (kill_mask)
);

// File: tb/test_shb_hint_redirect.sv
`timescale 1ns/1ps
module test_shb_hint_redirect;
  localparam int L  = 5;
  localparam int AW = 32;
  localparam int LW = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [L-1:0]    v, pp, j, h;
  logic [L*8-1:0]  pb;
  logic [L*AW-1:0] tg, pc;
  logic            fl;
  logic            rd_valid;
  logic [AW-1:0]   rd_target, rd_pc;
  logic [LW-1:0]   rd_lane;
  logic [L-1:0]    kill_mask;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  shb_hint_redirect #(.LANES(L), .AW(AW)) i_shb_hint_redirect (
    .clk(clk), .rst_n(rst_n), .dec_valid(v), .dec_pfx_present(pp),
    .dec_pfx_byte(pb), .dec_is_jcc(j), .dec_target(tg), .dec_pc(pc),
    .bp_hit(h), .be_flush(fl), .rd_valid(rd_valid), .rd_target(rd_target),
    .rd_pc(rd_pc), .rd_lane(rd_lane), .kill_mask(kill_mask));

  // Reference: oldest lane with a taken hint on a conditional branch and no predictor entry
  function automatic int ref_winner();
    for (int i = 0; i < L; i++)
      if (v[i] && pp[i] && pb[i*8 +: 8] == 8'h3E && j[i] && !h[i]) return i;
    return -1;
  endfunction

  task automatic clear_lanes();
    v = '0; pp = '0; pb = '0; j = '0; h = '0; fl = 1'b0;
    for (int i = 0; i < L; i++) begin
      tg[i*AW +: AW] = 32'h4000_0000 + 32'(i * 32'h100);
      pc[i*AW +: AW] = 32'h0010_0000 + 32'(i * 4);
    end
  endtask

  task automatic set_lane(input int i, input logic vv, input logic pr, input logic [7:0] b,
                          input logic jc, input logic hit);
    v[i] = vv; pp[i] = pr; pb[i*8 +: 8] = b; j[i] = jc; h[i] = hit;
  endtask

  // Drive the current vector, wait one edge, compare at the next falling edge
  task automatic apply_check(input string tag);
    int w;
    logic          e_v;
    logic [AW-1:0] e_t, e_p;
    logic [LW-1:0] e_l;
    logic [L-1:0]  e_k;
    w   = ref_winner();
    e_v = (w >= 0) && !fl;
    e_t = e_v ? tg[w*AW +: AW] : '0;
    e_p = e_v ? pc[w*AW +: AW] : '0;
    e_l = e_v ? LW'(w) : '0;
    e_k = '0;
    if (e_v) for (int k = 0; k < L; k++) e_k[k] = (k > w);
    @(negedge clk);
    checks++;
    if (rd_valid !== e_v || kill_mask !== e_k ||
        (e_v && (rd_target !== e_t || rd_pc !== e_p || rd_lane !== e_l))) begin
      fails++;
      $display("FAIL %s: got v=%0b tgt=%h pc=%h lane=%0d kill=%b, exp v=%0b tgt=%h pc=%h lane=%0d kill=%b",
               tag, rd_valid, rd_target, rd_pc, rd_lane, kill_mask, e_v, e_t, e_p, e_l, e_k);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: run did not complete, exp completion");
    finish_run();
  end

  initial begin
    clear_lanes();
    set_lane(0, 1, 1, 8'h3E, 1, 0);
    repeat (3) @(negedge clk);
    checks++;
    if (rd_valid !== 1'b0 || kill_mask !== '0) begin
      fails++;
      $display("FAIL R1: got v=%0b kill=%b, exp v=0 kill=0", rd_valid, kill_mask);
    end
    rst_n = 1'b1;
    clear_lanes();
    apply_check("R1");

    // R2: lone taken hint in the middle lane
    clear_lanes(); set_lane(2, 1, 1, 8'h3E, 1, 0); apply_check("R2");
    // R9: following idle cycle drops the pulse
    clear_lanes(); apply_check("R9");
    // R3: not-taken hint
    clear_lanes(); set_lane(1, 1, 1, 8'h2E, 1, 0); apply_check("R3");
    // R4: predictor already has the branch
    clear_lanes(); set_lane(0, 1, 1, 8'h3E, 1, 1); apply_check("R4");
    // R5: hint on a non-branch, and hint byte without prefix present
    clear_lanes(); set_lane(3, 1, 1, 8'h3E, 0, 0); apply_check("R5");
    clear_lanes(); set_lane(3, 1, 0, 8'h3E, 1, 0); apply_check("R5");
    // R10: invalid lane
    clear_lanes(); set_lane(4, 0, 1, 8'h3E, 1, 0); apply_check("R10");
    // R6 / R7: two hinted branches, older wins and younger lanes are killed
    clear_lanes(); set_lane(1, 1, 1, 8'h3E, 1, 0); set_lane(3, 1, 1, 8'h3E, 1, 0);
    apply_check("R6");
    // R7: winner in youngest lane leaves an empty kill mask; in lane 0 kills all others
    clear_lanes(); set_lane(4, 1, 1, 8'h3E, 1, 0); apply_check("R7");
    clear_lanes(); set_lane(0, 1, 1, 8'h3E, 1, 0); set_lane(2, 1, 1, 8'h3E, 1, 0);
    apply_check("R7");
    // R8: back-end flush suppresses
    clear_lanes(); set_lane(2, 1, 1, 8'h3E, 1, 0); fl = 1'b1; apply_check("R8");
    // R4 + R6: predicted older branch does not block a younger hinted one
    clear_lanes(); set_lane(0, 1, 1, 8'h3E, 1, 1); set_lane(3, 1, 1, 8'h3E, 1, 0);
    apply_check("R6");

    // Constrained random mix, seeded
    begin
      int unsigned seed_dummy;
      seed_dummy = $urandom(32'd1234);
    end
    for (int n = 0; n < 3000; n++) begin
      for (int i = 0; i < L; i++) begin
        logic [7:0] b;
        case ($urandom % 5)
          0, 1:    b = 8'h3E;
          2:       b = 8'h2E;
          3:       b = 8'h26;
          default: b = 8'hF3;
        endcase
        set_lane(i, ($urandom % 4) != 0, ($urandom % 5) < 3, b,
                 ($urandom % 5) < 3, ($urandom % 5) < 2);
        tg[i*AW +: AW] = $urandom;
        pc[i*AW +: AW] = $urandom;
      end
      fl = ($urandom % 10) == 0;
      apply_check("R2/R6/R7 random");
    end
    finish_run();
  end
endmodule